// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block raises a periodic interrupt at one of six rates chosen by a 3-bit select field in an 8-bit control register. It counts pulses of a prescaled time-base tick input, which runs at `TICK_HZ` (256 Hz by default). Each time a full period of the chosen rate has elapsed, it sets a sticky event flag. The flag and the select field share the register. Software polls or takes the interrupt, then clears the flag by writing the register with the flag bit at zero and the select bits unchanged.

The supported rates are 256, 64, 16, 4, 2 and 1 Hz. Select codes 0 and 7 switch event generation off. A write that changes the select code restarts the internal period divider, so the first event at the new rate arrives one full new period after the write. Skipping every other event to obtain intermediate rates is left to software.

Top module: `pirq_gen`

## Requirements
- R1: After reset the register reads 0x00 and `irq_o` is low.
- R2: The register reads back with the event flag in bit 7, the select code in bits 6..4, and bits 3..0 always zero. A write loads bits 6..4 into the select field on the next clock edge.
- R3: With `TICK_HZ`=256, select code 1 sets the flag on every tick. Code 2 sets it every 4 ticks, code 3 every 16, code 4 every 64, code 5 every 128 and code 6 every 256. Ticks are counted from the write that set the code.
- R4: Select codes 0 and 7 never set the flag, however many ticks arrive.
- R5: Writing the register with bit 7 at 0 clears the flag. Writing it with bit 7 at 1 leaves the flag as it was.
- R6: When a period ends in the same cycle as a write that clears the flag, the flag ends up set. An event that arrives while the flag is already set leaves it set.
- R7: A write whose select code differs from the current one restarts the period count. A write that repeats the current code does not restart it.
- R8: `irq_o` is high exactly when the flag is set and the select code is in the range 1..6.
- R9: The period advances only in cycles where `tick_i` is high. Idle cycles between ticks do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse of the prescaled time base |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The bench builds the block with the default `TICK_HZ` of 256. At that setting, every rate code divides the tick by at most 256, so the slowest rate completes a full period within a few hundred clock cycles. This puts both the one-tick-short and the exact-period boundary of all six codes within reach of a short run. Driving ticks back to back, and also with idle gaps, separates the tick count from the clock count.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int REG_W    = 8;
    localparam int SEL_W    = 3;
    localparam int FLAG_BIT = 7;
    localparam int SEL_LSB  = 4;
    localparam int BASE_LOG = 8;   // log2 of the fastest rate in Hz

    typedef logic [SEL_W-1:0] rate_sel_t;

    // log2 of the divide ratio relative to a 256 Hz base; -1 means off
    function automatic int rate_shift(rate_sel_t s);
        case (s)
            3'd1:    return 0;
            3'd2:    return 2;
            3'd3:    return 4;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            default: return -1;
        endcase
    endfunction
endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode
    import pirq_pkg::*;
#(
    parameter int TICK_HZ = 256
) (
    input  rate_sel_t                    sel_i,
    output logic                         active_o,
    output logic [$clog2(TICK_HZ)-1:0]   last_o
);
    localparam int CNT_W     = $clog2(TICK_HZ);
    localparam int PRE_SHIFT = CNT_W - BASE_LOG;

    logic [CNT_W:0] span;
    int             sh;

    always_comb begin
        sh       = rate_shift(sel_i);
        active_o = (sh >= 0);
        span     = '0;
        if (sh >= 0) begin
            span = (CNT_W+1)'(1) << (sh + PRE_SHIFT);
        end
        last_o = active_o ? CNT_W'(span - (CNT_W+1)'(1)) : '0;
    end
endmodule

// File: rtl/pirq_divider.sv
module pirq_divider #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic [CNT_W-1:0] last_i,
    input  logic             active_i,
    input  logic             restart_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             event_o
);
    always_comb begin
        cnt_d_o = cnt_q_i;
        event_o = 1'b0;
        if (restart_i || !active_i) begin
            cnt_d_o = '0;
        end else if (tick_i) begin
            if (cnt_q_i >= last_i) begin
                event_o = 1'b1;
                cnt_d_o = '0;
            end else begin
                cnt_d_o = cnt_q_i + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pirq_gen.sv
module pirq_gen
    import pirq_pkg::*;
#(
    parameter int TICK_HZ = 256
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o
);
    localparam int CNT_W = $clog2(TICK_HZ);

    typedef struct packed {
        logic             flag;
        rate_sel_t        sel;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t           st_q, st_d;
    logic             active;
    logic [CNT_W-1:0] last;
    logic             restart;
    logic             evt;
    logic [CNT_W-1:0] cnt_nxt;
    rate_sel_t        wr_sel;

    assign wr_sel  = wr_data_i[SEL_LSB +: SEL_W];
    assign restart = wr_en_i && (wr_sel != st_q.sel);

    pirq_rate_decode #(.TICK_HZ(TICK_HZ)) u_dec (
        .sel_i    (st_q.sel),
        .active_o (active),
        .last_o   (last)
    );

    pirq_divider #(.CNT_W(CNT_W)) u_div (
        .cnt_q_i   (st_q.cnt),
        .last_i    (last),
        .active_i  (active),
        .restart_i (restart),
        .tick_i    (tick_i),
        .cnt_d_o   (cnt_nxt),
        .event_o   (evt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
        if (wr_en_i) begin
            st_d.sel = wr_sel;
            if (!wr_data_i[FLAG_BIT]) begin
                st_d.flag = 1'b0;
            end
        end
        if (evt) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o                     = '0;
        rd_data_o[FLAG_BIT]           = st_q.flag;
        rd_data_o[SEL_LSB +: SEL_W]   = st_q.sel;
    end

    assign irq_o = st_q.flag && active;
endmodule

// File: rtl/pirq_gen_chk.sv
module pirq_gen_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       irq_o
);
    logic [2:0] sel;
    logic       off;
    assign sel = rd_data_o[6:4];
    assign off = (sel == 3'd0) || (sel == 3'd7);

    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[3:0] == 4'h0);                                            // R2
    AST_SEL_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (rd_data_o[6:4] == $past(wr_data_i[6:4])));             // R2
    AST_FASTEST_EVERY_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel == 3'd1 && tick_i && !wr_en_i) |=> rd_data_o[7]);              // R3
    AST_OFF_NEVER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (off && !rd_data_o[7]) |=> !rd_data_o[7]);                          // R4
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[7] && !(wr_en_i && !wr_data_i[7])) |=> rd_data_o[7]);    // R5
    AST_CLEAR_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_data_i[7] && !tick_i) |=> !rd_data_o[7]);           // R5
    AST_IRQ_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        off |-> !irq_o);                                                    // R8
    AST_NO_TICK_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !rd_data_o[7]) |=> !rd_data_o[7]);                      // R9
endmodule

bind pirq_gen pirq_gen_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o)
);

// File: tb/pirq_gen_test.sv
module pirq_gen_test;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;   // 200 MHz

    pirq_gen #(.TICK_HZ(256)) uut (
        .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_data_i, .rd_data_o, .irq_o
    );

    localparam int NV = 14;
    localparam int VSEL [NV] = '{1, 1, 2, 2, 3,  3,  4,  4,  5,   5,   6,   6,   0,   7};
    localparam int VTCK [NV] = '{1, 0, 3, 4, 15, 16, 63, 64, 127, 128, 255, 256, 300, 300};
    localparam int VEXP [NV] = '{1, 0, 0, 1, 0,  1,  0,  1,  0,   1,   0,   1,   0,   0};

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk_i);
        wr_en_i   = 1'b1;
        wr_data_i = d;
        @(negedge clk_i);
        wr_en_i   = 1'b0;
    endtask

    // n ticks back to back, returns at the negedge after the last one took effect
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            tick_i = 1'b1;
        end
        @(negedge clk_i);
        tick_i = 1'b0;
    endtask

    task automatic set_rate(int s);
        wr(8'h00);
        wr(8'(s << 4));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1 reg", rd_data_o, 8'h00);
        check("R1 irq", irq_o, 0);
        rst_ni = 1'b1;

        // Table walk over rates and boundaries
        for (int v = 0; v < NV; v++) begin
            set_rate(VSEL[v]);
            ticks(VTCK[v]);
            check((VSEL[v] == 0 || VSEL[v] == 7) ? "R4 flag" : "R3 flag",
                  rd_data_o[7], VEXP[v]);
            check("R8 irq", irq_o, VEXP[v]);
        end

        // R2 read format: low bits written as ones read back as zero
        wr(8'h5F);
        check("R2 format", rd_data_o, 8'h50);

        // R5 writing 1 to the flag bit keeps it, writing 0 clears it
        set_rate(1);
        ticks(1);
        wr(8'h90);
        check("R5 keep", rd_data_o, 8'h90);
        wr(8'h10);
        check("R5 clear", rd_data_o, 8'h10);

        // R6 event in the same cycle as a clearing write
        ticks(1);
        @(negedge clk_i);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'h10;
        @(negedge clk_i);
        tick_i = 1'b0; wr_en_i = 1'b0;
        check("R6 event wins", rd_data_o[7], 1);
        ticks(2);
        check("R6 stays set", rd_data_o[7], 1);

        // R8 flag set but select switched to 7 keeps the flag, drops irq
        wr(8'hF0);
        check("R8 flag kept", rd_data_o, 8'hF0);
        check("R8 irq off", irq_o, 0);

        // R7 changing code restarts the divider
        set_rate(2);
        ticks(2);
        wr(8'h30);
        ticks(15);
        check("R7 restart short", rd_data_o[7], 0);
        ticks(1);
        check("R7 restart full", rd_data_o[7], 1);

        // R7 same code rewrite does not restart
        set_rate(2);
        ticks(2);
        wr(8'h20);
        ticks(2);
        check("R7 no restart", rd_data_o[7], 1);

        // R9 idle cycles between ticks are not counted
        set_rate(2);
        for (int i = 0; i < 3; i++) begin
            ticks(1);
            repeat (5) @(negedge clk_i);
        end
        check("R9 three spaced", rd_data_o[7], 0);
        ticks(1);
        check("R9 fourth", rd_data_o[7], 1);

        // R1 reset mid-run
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R1 re-reset", rd_data_o, 8'h00);
        rst_ni = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule